// File: doc/BRIEF.md
# Pipelined Read Output Stage with Selectable Deselect Timing

This block sits between the command inputs of a pipelined synchronous memory and its shared data bus. It registers each command, presents the registered address to the storage array, captures the returned read word into an output register, and decides cycle by cycle whether the data bus drivers are on. Reads turn the drivers on. Writes and deselects turn them off.

The off timing after a deselect has two modes, chosen by a mode input. In the dual-cycle mode, a deselect travels as deep through the pipeline as a read. In the single-cycle mode, which is the mode when the input is tied low, a deselect takes effect one stage earlier. A write always removes drive as soon as it is registered, so the bus is free for incoming write data. An asynchronous output-enable gates the drivers directly.

The write side turns the global write, byte-write enable and per-byte select inputs into a registered per-byte write strobe, together with the registered write data.

Top module: `sram_out_stage`

## Requirements
- R1: While rst_ni is low, drive_en_o, arr_we_o and rdata_o are all zero.
- R2: A read is a cycle with cmd_vld_i=1, cs_i=1 and rd_i=1, sampled at edge k. arr_addr_o shows its address after edge k. At edge k+1, rdata_o loads the arr_rdata_i value, and drive_en_o is then high when oe_i is high and no write or deselect has followed.
- R3: With dcd_sel_i=1 (dual-cycle), a deselect (cmd_vld_i=1, cs_i=0) sampled at edge k leaves drive_en_o at its prior state until edge k+1 and turns it off after edge k+1.
- R4: With dcd_sel_i=0 (single-cycle, the tied-low default), a deselect sampled at edge k turns drive_en_o off immediately after edge k.
- R5: A write (cmd_vld_i=1, cs_i=1, rd_i=0) sampled at edge k turns drive_en_o off immediately after edge k, in both modes. Drive stays off until a later read.
- R6: A cycle with cmd_vld_i=0 changes neither the drive state nor rdata_o.
- R7: With oe_i low, drive_en_o is low at once, without waiting for a clock edge. Raising oe_i again restores the registered drive state at once.
- R8: On a write with gw_i=0 and bw_en_i=1, bit b of arr_we_o equals byte_sel_i[b] in the cycle after edge k. Bit b strobes data bits [b*BYTE_W +: BYTE_W]. arr_wdata_o carries the wdata_i sampled at edge k.
- R9: On a write with gw_i=1, every bit of arr_we_o is set, whatever bw_en_i and byte_sel_i hold.
- R10: arr_we_o is all zero after any edge that sampled no write, and after a write with gw_i=0 and bw_en_i=0.
- R11: rdata_o holds its last read word through writes, deselects and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Command present this cycle |
| cs_i | input | 1 | Chip select; low with cmd_vld_i means deselect |
| rd_i | input | 1 | 1 = read, 0 = write (with cs_i high) |
| addr_i | input | ADDR_W | Command address |
| dcd_sel_i | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle |
| oe_i | input | 1 | Asynchronous output enable |
| gw_i | input | 1 | Global write: all bytes |
| bw_en_i | input | 1 | Byte-write enable |
| byte_sel_i | input | BYTES | Per-byte write select |
| wdata_i | input | BYTES*BYTE_W | Write data |
| arr_rdata_i | input | BYTES*BYTE_W | Array read word for arr_addr_o |
| arr_addr_o | output | ADDR_W | Registered address to the array |
| arr_we_o | output | BYTES | Registered per-byte write strobe |
| arr_wdata_o | output | BYTES*BYTE_W | Registered write data |
| rdata_o | output | BYTES*BYTE_W | Registered read data |
| drive_en_o | output | 1 | Data bus driver enable |

## Verification
The bench builds the block with ADDR_W=8, BYTES=4 and BYTE_W=9. With only four byte lanes, random select patterns reach the all-zero and all-ones masks often, so byte, global and empty writes all come up. The 36-bit word keeps each byte's position distinct in the write data comparison. The random command streams run under both settings of dcd_sel_i, so reads followed directly by deselects and writes show the one-cycle difference between the two modes.

// File: rtl/sos_pkg.sv
package sos_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_DESEL = 2'd3
  } cmd_e;
endpackage

// File: rtl/sos_cmd_reg.sv
module sos_cmd_reg
  import sos_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BYTES  = 8,
  parameter int BYTE_W = 9,
  localparam int DW    = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gw_i,
  input  logic              bw_en_i,
  input  logic [BYTES-1:0]  byte_sel_i,
  input  logic [DW-1:0]     wdata_i,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTES-1:0]  we_o,
  output logic [DW-1:0]     wdata_o
);
  cmd_e             cmd_d, cmd_q;
  logic [BYTES-1:0] mask_d, mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]    wdata_q;

  always_comb begin
    if (!cmd_vld_i)  cmd_d = CMD_NONE;
    else if (!cs_i)  cmd_d = CMD_DESEL;
    else if (rd_i)   cmd_d = CMD_READ;
    else             cmd_d = CMD_WRITE;
  end

  // global write overrides byte controls
  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign mask_d[b] = gw_i | (bw_en_i & byte_sel_i[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_NONE;
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      mask_q <= (cmd_d == CMD_WRITE) ? mask_d : '0;
      if (cmd_d != CMD_NONE) addr_q <= addr_i;
      if (cmd_d == CMD_WRITE) wdata_q <= wdata_i;
    end
  end

  assign cmd_o   = cmd_q;
  assign addr_o  = addr_q;
  assign we_o    = mask_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/sos_drive_ctrl.sv
module sos_drive_ctrl
  import sos_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic dcd_sel_i,
  input  logic oe_i,
  output logic drive_en_o
);
  logic drv_q;
  logic early_off;

  // second stage: same depth as read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else begin
      unique case (cmd_i)
        CMD_READ:             drv_q <= 1'b1;
        CMD_WRITE, CMD_DESEL: drv_q <= 1'b0;
        default:              drv_q <= drv_q;
      endcase
    end
  end

  // first stage: writes always, deselects only in single-cycle mode
  assign early_off = (cmd_i == CMD_WRITE) || (!dcd_sel_i && cmd_i == CMD_DESEL);

  assign drive_en_o = oe_i & drv_q & ~early_off;
endmodule

// File: rtl/sos_rdata_reg.sv
module sos_rdata_reg #(
  parameter int DW = 72
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sos_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BYTES  = 8,
  parameter int BYTE_W = 9,
  localparam int DW    = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dcd_sel_i,
  input  logic              oe_i,
  input  logic              gw_i,
  input  logic              bw_en_i,
  input  logic [BYTES-1:0]  byte_sel_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     arr_rdata_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [BYTES-1:0]  arr_we_o,
  output logic [DW-1:0]     arr_wdata_o,
  output logic [DW-1:0]     rdata_o,
  output logic              drive_en_o
);
  cmd_e s1_cmd;

  sos_cmd_reg #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_cmd (
    .clk_i, .rst_ni, .cmd_vld_i, .cs_i, .rd_i, .addr_i,
    .gw_i, .bw_en_i, .byte_sel_i, .wdata_i,
    .cmd_o   (s1_cmd),
    .addr_o  (arr_addr_o),
    .we_o    (arr_we_o),
    .wdata_o (arr_wdata_o)
  );

  sos_drive_ctrl u_drv (
    .clk_i, .rst_ni,
    .cmd_i      (s1_cmd),
    .dcd_sel_i,
    .oe_i,
    .drive_en_o
  );

  sos_rdata_reg #(.DW(DW)) u_rdat (
    .clk_i, .rst_ni,
    .load_i (s1_cmd == CMD_READ),
    .d_i    (arr_rdata_i),
    .q_o    (rdata_o)
  );
endmodule

// File: rtl/sram_out_stage_chk.sv
module sram_out_stage_chk #(
  parameter int BYTES = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_vld_i,
  input logic             cs_i,
  input logic             rd_i,
  input logic             dcd_sel_i,
  input logic             oe_i,
  input logic             gw_i,
  input logic [BYTES-1:0] arr_we_o,
  input logic             drive_en_o
);
  logic is_rd, is_wr, is_ds;
  assign is_rd = cmd_vld_i & cs_i & rd_i;
  assign is_wr = cmd_vld_i & cs_i & ~rd_i;
  assign is_ds = cmd_vld_i & ~cs_i;

  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !drive_en_o);

  // R2
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd ##1 !cmd_vld_i |=> (drive_en_o || !oe_i));

  // R3
  dcd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ds && dcd_sel_i) ##1 dcd_sel_i |=> !drive_en_o);

  // R4
  scd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ds && !dcd_sel_i) |=> (dcd_sel_i || !drive_en_o));

  // R5
  write_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> !drive_en_o);

  // R9
  global_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && gw_i) |=> (&arr_we_o));

  // R10
  no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_wr |=> (arr_we_o == '0));
endmodule

bind sram_out_stage sram_out_stage_chk #(.BYTES(BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld_i), .cs_i(cs_i),
  .rd_i(rd_i), .dcd_sel_i(dcd_sel_i), .oe_i(oe_i), .gw_i(gw_i),
  .arr_we_o(arr_we_o), .drive_en_o(drive_en_o)
);

// File: tb/sram_out_stage_bench.sv
module sram_out_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int BYTES  = 4;
  localparam int BYTE_W = 9;
  localparam int DW     = BYTES * BYTE_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_vld_i = 0, cs_i = 0, rd_i = 0, dcd_sel_i = 0, oe_i = 1;
  logic gw_i = 0, bw_en_i = 0;
  logic [BYTES-1:0]  byte_sel_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DW-1:0]     wdata_i = '0;
  logic [DW-1:0]     arr_rdata_i;
  logic [ADDR_W-1:0] arr_addr_o;
  logic [BYTES-1:0]  arr_we_o;
  logic [DW-1:0]     arr_wdata_o, rdata_o;
  logic              drive_en_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [DW-1:0] mem_fn(input logic [ADDR_W-1:0] a);
    logic [39:0] w;
    w = {a, a, a, a, a} ^ 40'h3C_95A3_0F71;
    return w[DW-1:0];
  endfunction

  assign arr_rdata_i = mem_fn(arr_addr_o);

  sram_out_stage #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_sram_out_stage (.*);

  // bench model: 0 none, 1 read, 2 write, 3 deselect
  logic [1:0]        m_cmd = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [BYTES-1:0]  m_mask = '0;
  logic [DW-1:0]     m_wdata = '0, m_rdata = '0;
  logic              m_drv = 0, m_gw = 0, m_rd_loaded = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cmd <= 0; m_addr <= '0; m_mask <= '0; m_wdata <= '0;
      m_rdata <= '0; m_drv <= 0; m_gw <= 0; m_rd_loaded <= 0;
    end else begin
      m_rd_loaded <= (m_cmd == 1);
      if (m_cmd == 1) m_rdata <= mem_fn(m_addr);
      if (m_cmd == 1) m_drv <= 1;
      else if (m_cmd != 0) m_drv <= 0;
      m_cmd <= !cmd_vld_i ? 2'd0 : !cs_i ? 2'd3 : rd_i ? 2'd1 : 2'd2;
      if (cmd_vld_i) m_addr <= addr_i;
      m_gw <= gw_i;
      if (cmd_vld_i && cs_i && !rd_i) begin
        m_wdata <= wdata_i;
        m_mask  <= gw_i ? {BYTES{1'b1}} : (bw_en_i ? byte_sel_i : '0);
      end else m_mask <= '0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_drive();
    return oe_i & m_drv & !(m_cmd == 2 || (!dcd_sel_i && m_cmd == 3));
  endfunction

  task automatic check_all();
    string t;
    case (m_cmd)
      2'd1: t = "R2";
      2'd2: t = "R5";
      2'd3: t = dcd_sel_i ? "R3" : "R4";
      default: t = "R6";
    endcase
    chk({t, " drive"}, 64'(drive_en_o), 64'(exp_drive()));
    chk(m_rd_loaded ? "R2 rdata" : "R11 rdata", 64'(rdata_o), 64'(m_rdata));
    if (m_cmd != 0) chk("R2 addr", 64'(arr_addr_o), 64'(m_addr));
    if (m_cmd != 2 || m_mask == '0) chk("R10 strobe", 64'(arr_we_o), 64'(m_mask));
    else if (m_gw) chk("R9 strobe", 64'(arr_we_o), 64'(m_mask));
    else chk("R8 strobe", 64'(arr_we_o), 64'(m_mask));
    if (m_cmd == 2) chk("R8 wdata", 64'(arr_wdata_o), 64'(m_wdata));
  endtask

  task automatic cyc(input logic v, input logic c, input logic r, input logic [ADDR_W-1:0] a,
                     input logic g, input logic b, input logic [BYTES-1:0] s);
    @(negedge clk_i);
    cmd_vld_i = v; cs_i = c; rd_i = r; addr_i = a;
    gw_i = g; bw_en_i = b; byte_sel_i = s;
    wdata_i = DW'({$urandom, $urandom});
    @(posedge clk_i); #1;
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #(CLK_PERIOD * 2 + 1);
    // R1
    chk("R1 drive", 64'(drive_en_o), 0);
    chk("R1 strobe", 64'(arr_we_o), 0);
    chk("R1 rdata", 64'(rdata_o), 0);
    @(negedge clk_i); rst_ni = 1;

    // dual-cycle: read, then deselect keeps drive one more cycle (R3)
    dcd_sel_i = 1;
    cyc(1, 1, 1, 8'h21, 0, 0, '0);
    cyc(0, 0, 0, 8'h00, 0, 0, '0);
    chk("R2 drive on", 64'(drive_en_o), 1);
    // R7 asynchronous gating mid-cycle
    #2 oe_i = 0; #1 chk("R7 oe low", 64'(drive_en_o), 0);
    oe_i = 1; #1 chk("R7 oe high", 64'(drive_en_o), 1);
    cyc(1, 0, 0, 8'h00, 0, 0, '0);
    chk("R3 held", 64'(drive_en_o), 1);
    cyc(0, 0, 0, 8'h00, 0, 0, '0);
    chk("R3 off", 64'(drive_en_o), 0);

    // single-cycle: deselect cuts drive at once (R4)
    dcd_sel_i = 0;
    cyc(1, 1, 1, 8'h5e, 0, 0, '0);
    cyc(0, 0, 0, 8'h00, 0, 0, '0);
    cyc(1, 0, 0, 8'h00, 0, 0, '0);
    chk("R4 off", 64'(drive_en_o), 0);
    // writes: byte (R8), global (R9), empty (R10), off (R5)
    cyc(1, 1, 0, 8'h10, 0, 1, 4'b0101);
    chk("R5 write off", 64'(drive_en_o), 0);
    cyc(1, 1, 0, 8'h11, 1, 0, 4'b0000);
    cyc(1, 1, 0, 8'h12, 0, 0, 4'b1111);
    chk("R11 rdata hold", 64'(rdata_o), 64'(mem_fn(8'h5e)));

    for (int p = 0; p < 2; p++) begin
      dcd_sel_i = p[0];
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk_i) oe_i = ($urandom_range(0, 9) != 0);
        cyc($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1,
            ADDR_W'($urandom), $urandom_range(0, 5) == 0, $urandom_range(0, 1) == 1,
            BYTES'($urandom));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule